// File: doc/BRIEF.md
# Serial LED Channel Driver Controller with Fault Readback

This block is the digital control core of a 16-channel constant-current LED driver. A host clocks channel data in one bit per clock edge on `ser_in`. The register's last stage appears on `ser_out`, so several cores can be chained. A storage register takes the shifted pattern while `latch_en` is high. The active-low `oe_n` pin then gates that pattern onto the per-channel enables `chan_on`, which switch the analog current sinks.

The two control pins have a second role, so no extra pins are needed. A fixed five-edge pattern on `oe_n` and `latch_en` puts the core into diagnostic mode, and a second pattern returns it to run mode. In diagnostic mode, a low pulse on `oe_n` captures a 2-bit fault code for each channel from the sensing circuits. The core reduces each code to a pass or fail bit, loads the 16 results into the shift register in parallel, and then shifts them out on `ser_out`. The analog sensing and current regulation are outside this block.

All inputs are sampled on the rising edge of `clk`, which is the serial clock. Reset is asynchronous and active low.

Top module: `ledsr_core`

## Requirements
- R1: While reset is asserted and right after it is released, `chan_on` is all zeros, `ser_out` is 0 and `diag_mode` is 0 (run mode).
- R2: In run mode, every rising edge shifts the register by one place toward the MSB and takes `ser_in` into bit 0. `ser_out` shows bit 15, so a bit sampled on `ser_in` appears on `ser_out` after 16 edges.
- R3: On every edge where `latch_en` is sampled high, the storage register takes the shift register's new contents after that edge's shift or load. While `latch_en` is low, the storage register holds its value.
- R4: `chan_on` equals the storage register while `oe_n` is low. It is all zeros while `oe_n` is high, whatever the storage register holds.
- R5: In run mode, the core switches to diagnostic mode after five consecutive edges on which `oe_n` is sampled 1,0,1,0,1 and `latch_en` is sampled 0,0,0,1,0. `diag_mode` reads 1 from the fifth edge on, and not before it.
- R6: In diagnostic mode, the core returns to run mode after five consecutive edges on which `oe_n` is sampled 1,0,1,0,1 and `latch_en` is sampled low on all five.
- R7: Any other pattern leaves the mode unchanged. The return pattern has no effect in run mode, and the entry pattern has no effect in diagnostic mode.
- R8: In diagnostic mode, an edge where `oe_n` is sampled low and was sampled high on the previous edge loads the fault results instead of shifting. Bit i of the result is 1 when `flt_code[2i+1:2i]` is 00 (no fault). It is 0 for 01 (open line), 10 (short to ground) or 11 (short to supply).
- R9: After a fault load, `ser_out` shows channel 15's result first. Each later edge shifts one place, so the results of channels 14 down to 0 follow one per edge.
- R10: If `oe_n` stays low over several edges in diagnostic mode, only the first of those edges loads. The following edges shift normally.
- R11: In run mode, a high-to-low change of `oe_n` never loads fault results, and shifting continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data input |
| latch_en | input | 1 | Storage load enable; also part of the mode patterns |
| oe_n | input | 1 | Active-low output gate; also mode pattern and fault capture strobe |
| flt_code | input | 32 | Per-channel 2-bit fault code, channel i at bits 2i+1:2i |
| ser_out | output | 1 | Serial output, MSB of the shift register |
| chan_on | output | 16 | Per-channel current sink enables |
| diag_mode | output | 1 | High while in diagnostic mode |

## Verification
The corner cases the bench targets are these:
- The exact edge on which the mode changes. A detector that is off by one edge would raise `diag_mode` on the fourth edge, or on the sixth.
- Near-miss patterns, such as `latch_en` high on the wrong edge or `oe_n` missing a pulse. A loose matcher would accept these.
- The run-mode return pattern. A matcher that ignores the current mode would act on it.
- An `oe_n` low held across several edges. A level-triggered load would reload on every one of those edges and freeze `ser_out` on channel 15.
- Fault codes swept so that every channel sees all four values. Swapped code meanings, or a reversed readback order, show up as wrong bits on `ser_out`.
- The output gate and the latch hold, checked after every step of the sweep.

// File: rtl/ledsr_pkg.sv
package ledsr_pkg;

    localparam int SEQ_LEN = 5;

    // oldest sample in the MSB, newest in the LSB
    localparam logic [SEQ_LEN-1:0] OE_PATTERN = 5'b10101;
    localparam logic [SEQ_LEN-1:0] LE_ENTER   = 5'b00010;
    localparam logic [SEQ_LEN-1:0] LE_LEAVE   = 5'b00000;

    localparam logic [1:0] FLT_NONE  = 2'b00;
    localparam logic [1:0] FLT_OPEN  = 2'b01;
    localparam logic [1:0] FLT_GND   = 2'b10;
    localparam logic [1:0] FLT_SUPPLY = 2'b11;

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_DIAG = 1'b1
    } mode_e;

    typedef struct packed {
        logic [SEQ_LEN-1:0] oe_hist;
        logic [SEQ_LEN-1:0] le_hist;
        mode_e              mode;
    } seq_state_t;

endpackage

// File: rtl/ledsr_health.sv
module ledsr_health
    import ledsr_pkg::*;
#(
    parameter int N_CH = 16
) (
    input  logic [2*N_CH-1:0] flt_code,
    output logic [N_CH-1:0]   healthy
);

    // one comparator per channel: pass only when the code reads no fault
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        assign healthy[ch] = (flt_code[2*ch +: 2] == FLT_NONE);
    end

endmodule

// File: rtl/ledsr_shift.sv
module ledsr_shift #(
    parameter int N_CH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_in,
    input  logic            load_en,
    input  logic [N_CH-1:0] load_val,
    output logic [N_CH-1:0] shift_d,
    output logic [N_CH-1:0] shift_q
);

    always_comb begin
        if (load_en) begin
            shift_d = load_val;
        end else begin
            shift_d = {shift_q[N_CH-2:0], ser_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= shift_d;
        end
    end

endmodule

// File: rtl/ledsr_store.sv
module ledsr_store #(
    parameter int N_CH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            latch_en,
    input  logic [N_CH-1:0] data_in,
    output logic [N_CH-1:0] store_q
);

    logic [N_CH-1:0] store_d;

    always_comb begin
        store_d = store_q;
        if (latch_en) begin
            store_d = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

endmodule

// File: rtl/ledsr_mode.sv
module ledsr_mode
    import ledsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic latch_en,
    input  logic oe_n,
    output logic diag,
    output logic capture
);

    seq_state_t st_d;
    seq_state_t st_q;

    always_comb begin
        st_d         = st_q;
        st_d.oe_hist = {st_q.oe_hist[SEQ_LEN-2:0], oe_n};
        st_d.le_hist = {st_q.le_hist[SEQ_LEN-2:0], latch_en};

        if (st_d.oe_hist == OE_PATTERN) begin
            if (st_q.mode == MODE_RUN && st_d.le_hist == LE_ENTER) begin
                st_d.mode = MODE_DIAG;
            end else if (st_q.mode == MODE_DIAG && st_d.le_hist == LE_LEAVE) begin
                st_d.mode = MODE_RUN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{oe_hist: '0, le_hist: '0, mode: MODE_RUN};
        end else begin
            st_q <= st_d;
        end
    end

    assign diag    = (st_q.mode == MODE_DIAG);
    // first low sample after a high one, only in diagnostic mode
    assign capture = diag && !oe_n && st_q.oe_hist[0];

endmodule

// File: rtl/ledsr_core.sv
module ledsr_core #(
    parameter int N_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              latch_en,
    input  logic              oe_n,
    input  logic [2*N_CH-1:0] flt_code,
    output logic              ser_out,
    output logic [N_CH-1:0]   chan_on,
    output logic              diag_mode
);

    logic [N_CH-1:0] healthy;
    logic [N_CH-1:0] shift_d;
    logic [N_CH-1:0] shift_q;
    logic [N_CH-1:0] store_q;
    logic            capture;

    ledsr_health #(.N_CH(N_CH)) i_health (
        .flt_code (flt_code),
        .healthy  (healthy)
    );

    ledsr_mode i_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_en (latch_en),
        .oe_n     (oe_n),
        .diag     (diag_mode),
        .capture  (capture)
    );

    ledsr_shift #(.N_CH(N_CH)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .load_en  (capture),
        .load_val (healthy),
        .shift_d  (shift_d),
        .shift_q  (shift_q)
    );

    ledsr_store #(.N_CH(N_CH)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_en (latch_en),
        .data_in  (shift_d),
        .store_q  (store_q)
    );

    assign ser_out = shift_q[N_CH-1];
    assign chan_on = oe_n ? '0 : store_q;

endmodule

// File: rtl/ledsr_chk.sv
module ledsr_chk #(
    parameter int N_CH = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            latch_en,
    input logic            oe_n,
    input logic [1:0]      top_code,
    input logic            ser_out,
    input logic [N_CH-1:0] chan_on,
    input logic            diag_mode,
    input logic            next_msb
);

    AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (chan_on == '0)); // R4

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && $past(!oe_n) && $past(!latch_en)) |-> $stable(chan_on)); // R3

    AST_SHIFT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!diag_mode) |-> (ser_out == $past(next_msb))); // R2

    AST_ENTER_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(diag_mode) |-> ($past(oe_n) && !$past(latch_en)
                              && $past(latch_en, 2) && !$past(oe_n, 2))); // R5

    AST_LEAVE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(diag_mode) |-> ($past(oe_n) && !$past(latch_en)
                              && !$past(latch_en, 2) && !$past(oe_n, 2))); // R6

    AST_FAULT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_mode && !oe_n && $past(oe_n)) |=> (ser_out == $past(top_code == 2'b00))); // R8

endmodule

bind ledsr_core ledsr_chk #(.N_CH(N_CH)) i_ledsr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_en  (latch_en),
    .oe_n      (oe_n),
    .top_code  (flt_code[2*N_CH-1 -: 2]),
    .ser_out   (ser_out),
    .chan_on   (chan_on),
    .diag_mode (diag_mode),
    .next_msb  (shift_q[N_CH-2])
);

// File: tb/test_ledsr_core.sv
module test_ledsr_core;

    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_in = 1'b0;
    logic          latch_en = 1'b0;
    logic          oe_n = 1'b1;
    logic [2*N-1:0] flt_code = '0;
    logic          ser_out;
    logic [N-1:0]  chan_on;
    logic          diag_mode;

    int total = 0;
    int bad = 0;

    // expected state, kept from the requirements
    logic [N-1:0] e_sh = '0;
    logic [N-1:0] e_st = '0;
    logic         e_diag = 1'b0;
    logic [4:0]   e_oeh = '0;
    logic [4:0]   e_leh = '0;

    always #10 clk = ~clk;

    ledsr_core #(.N_CH(N)) i_ledsr_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .latch_en  (latch_en),
        .oe_n      (oe_n),
        .flt_code  (flt_code),
        .ser_out   (ser_out),
        .chan_on   (chan_on),
        .diag_mode (diag_mode)
    );

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] pass_bits(input logic [2*N-1:0] codes);
        logic [N-1:0] r;
        for (int c = 0; c < N; c++) begin
            r[c] = (codes[2*c +: 2] == 2'b00);
        end
        return r;
    endfunction

    task automatic step(input logic s, input logic l, input logic o);
        logic         ld;
        logic         held;
        logic         run_fall;
        logic         old_diag;
        logic [N-1:0] nxt;
        string        tag;
        @(negedge clk);
        ser_in   = s;
        latch_en = l;
        oe_n     = o;
        ld       = e_diag && !o && e_oeh[0];
        held     = e_diag && !o && !e_oeh[0];
        run_fall = !e_diag && !o && e_oeh[0];
        nxt      = ld ? pass_bits(flt_code) : {e_sh[N-2:0], s};
        if (l) e_st = nxt;
        e_oeh    = {e_oeh[3:0], o};
        e_leh    = {e_leh[3:0], l};
        old_diag = e_diag;
        if (!e_diag && e_oeh == 5'b10101 && e_leh == 5'b00010) e_diag = 1'b1;
        else if (e_diag && e_oeh == 5'b10101 && e_leh == 5'b00000) e_diag = 1'b0;
        e_sh = nxt;
        @(posedge clk);
        #1;
        tag = ld ? "R8" : held ? "R10" : run_fall ? "R11" : old_diag ? "R9" : "R2";
        check(ser_out === e_sh[N-1], tag, 32'(ser_out), 32'(e_sh[N-1]));
        check(chan_on === (o ? '0 : e_st), o ? "R4" : "R3", 32'(chan_on),
              32'(o ? '0 : e_st));
        tag = (e_diag && !old_diag) ? "R5" : (!e_diag && old_diag) ? "R6" : "R7";
        check(diag_mode === e_diag, tag, 32'(diag_mode), 32'(e_diag));
    endtask

    task automatic pattern(input logic [4:0] oe_p, input logic [4:0] le_p);
        for (int k = 4; k >= 0; k--) begin
            step(1'b0, le_p[k], oe_p[k]);
        end
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [N-1:0] pats [5];
        pats[0] = 16'hA5C3; pats[1] = 16'hFFFF; pats[2] = 16'h0001;
        pats[3] = 16'h8000; pats[4] = 16'h3C96;

        // R1: reset state
        #35;
        check(chan_on === '0, "R1", 32'(chan_on), 0);
        check(ser_out === 1'b0, "R1", 32'(ser_out), 0);
        check(diag_mode === 1'b0, "R1", 32'(diag_mode), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(chan_on === '0 && ser_out === 1'b0 && diag_mode === 1'b0, "R1",
              {chan_on, 14'd0, ser_out, diag_mode}, 0);

        // R2, R3, R4: load patterns, latch on the last bit, gate on and off
        foreach (pats[p]) begin
            for (int b = N - 1; b >= 0; b--) begin
                step(pats[p][b], b == 0, 1'b1);
            end
            check(ser_out === pats[p][N-1], "R2", 32'(ser_out), 32'(pats[p][N-1]));
            step(1'b0, 1'b0, 1'b0);
            check(chan_on === pats[p], "R3", 32'(chan_on), 32'(pats[p]));
            step(1'b1, 1'b0, 1'b1);
            check(chan_on === '0, "R4", 32'(chan_on), 0);
        end

        // R3: hold while shifting with latch low and outputs on
        for (int k = 0; k < 20; k++) begin
            step(k[0] ^ k[2], 1'b0, 1'b0);
        end
        check(chan_on === pats[4], "R3", 32'(chan_on), 32'(pats[4]));

        // R3: latch enable kept high tracks every edge
        for (int k = 0; k < 8; k++) begin
            step(k[1], 1'b1, 1'b0);
        end

        // R7, R11: near misses and return pattern in run mode
        pattern(5'b10101, 5'b00000);
        check(diag_mode === 1'b0, "R7", 32'(diag_mode), 0);
        pattern(5'b10101, 5'b00100);
        pattern(5'b10001, 5'b00010);
        pattern(5'b11101, 5'b00010);
        check(diag_mode === 1'b0, "R7", 32'(diag_mode), 0);

        // R5: entry, not before the fifth edge
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b0);
        check(diag_mode === 1'b0, "R5", 32'(diag_mode), 0);
        step(1'b0, 1'b0, 1'b1);
        check(diag_mode === 1'b1, "R5", 32'(diag_mode), 1);

        // R8, R9, R10: fault sweep, each channel sees every code
        for (int p = 0; p < 8; p++) begin
            logic [N-1:0] exp_pass;
            for (int c = 0; c < N; c++) begin
                flt_code[2*c +: 2] = (p < 4) ? 2'((c + p) % 4)
                                   : (p == 4) ? 2'b00
                                   : (p == 5) ? 2'b11 : 2'((c * p) % 4);
            end
            exp_pass = pass_bits(flt_code);
            step(1'b0, 1'b0, 1'b1);
            step(1'b0, 1'b0, 1'b0);
            check(ser_out === exp_pass[N-1], "R8", 32'(ser_out), 32'(exp_pass[N-1]));
            step(1'b1, 1'b0, 1'b0);
            check(ser_out === exp_pass[N-2], "R10", 32'(ser_out), 32'(exp_pass[N-2]));
            for (int b = N - 3; b >= 0; b--) begin
                step(1'b0, 1'b0, 1'b1);
                check(ser_out === exp_pass[b], "R9", 32'(ser_out), 32'(exp_pass[b]));
            end
        end

        // R7: entry pattern while already in diagnostic mode
        pattern(5'b10101, 5'b00010);
        check(diag_mode === 1'b1, "R7", 32'(diag_mode), 1);

        // R6: return to run mode
        step(1'b0, 1'b0, 1'b1);
        pattern(5'b10101, 5'b00000);
        check(diag_mode === 1'b0, "R6", 32'(diag_mode), 0);

        // R11: oe_n pulse in run mode keeps shifting
        flt_code = '0;
        for (int k = 0; k < 6; k++) begin
            step(1'b0, 1'b0, k[0]);
        end
        for (int k = 0; k < N + 2; k++) begin
            step(k[0], 1'b0, 1'b1);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule